// File: doc/BRIEF.md
# PRBS7 Bit-Error-Rate Tester with Self-Seeding Checker

This block measures the bit error rate of a serial link. A transmit generator drives a seven-stage pseudo-random bit pattern, one bit per enabled clock. On the receive side, a checker locks onto the incoming pattern with no handshake. While it is acquiring, its LFSR has no feedback, and every received bit is shifted straight into the register. After seven bits, the register holds a copy of the transmitter state. Feedback is then closed, and the register runs freely to predict each following bit.

Each predicted bit is compared with the bit that arrives. While lock is held, the checker counts the bits it has compared and the mismatches it has found. A corrupted seed is detected in one of two ways: the seed is all zeros, or too many errors appear shortly after lock. In either case the checker goes back to acquisition and seeds again from new bits. A resync request clears the counters and restarts acquisition at any time.

Top module: `prbs_bert`

## Requirements
- R1: After reset, `locked` is 0, `err_count` and `bit_count` are 0, and `tx_valid` is 0.
- R2: The generator steps x^7 + x^6 + 1 from the seed `TX_SEED` (default 1). Each state holds seven bits, the oldest bit in bit 6. A step computes new = s[6] XOR s[5] and shifts it in at bit 0. On every clock edge where `tx_en` is high, the generator takes one step, `tx_bit` takes the new bit, and `tx_valid` is 1 after that edge. After an edge where `tx_en` is low, `tx_valid` is 0.
- R3: While unlocked, each bit with `rx_valid` high is shifted into the receive LFSR with no feedback. `locked` rises after the edge that accepts the seventh such bit, and not before.
- R4: While locked, each valid bit is compared with the prediction s[6] XOR s[5], and the LFSR advances with that prediction. Each valid bit increments `bit_count`, and each mismatch also increments `err_count`. Neither counter changes while unlocked.
- R5: A cycle with `rx_valid` low changes neither the LFSR, the lock state nor the counters.
- R6: If the seven seed bits are all zero, the checker stays unlocked and seeds again from the next seven valid bits.
- R7: The checker unlocks and reacquires if the fourth mismatch falls within the first 64 bits compared after lock. That bit is still counted. Mismatches after those 64 bits do not unlock the checker.
- R8: `resync` high at an edge clears both counters and the lock flag and restarts seeding. A valid bit in the same cycle is neither counted nor seeded.
- R9: Both counters are `CNT_W` bits wide (default 32) and hold at their maximum value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Advance the transmit pattern this cycle |
| tx_bit | output | 1 | Transmit pattern bit |
| tx_valid | output | 1 | `tx_bit` was produced on the last edge |
| rx_bit | input | 1 | Received bit |
| rx_valid | input | 1 | `rx_bit` is valid this cycle |
| resync | input | 1 | Clear counters and reacquire |
| err_count | output | CNT_W | Mismatches counted while locked |
| bit_count | output | CNT_W | Bits compared while locked |
| locked | output | 1 | Checker is tracking the pattern |

## Verification
The checker is locked and counting when a resync request arrives in the same cycle as a valid, correct bit. Resync must win that collision. The bench checks right after that edge that both counters are zero and lock is clear. It then sends six more bits and requires `locked` to stay low, and requires it to rise on the seventh. That proves the colliding bit was neither counted nor used in the seed.

// File: rtl/prbs_bert_pkg.sv
package prbs_bert_pkg;
  typedef enum logic {
    ST_ACQ   = 1'b0,
    ST_TRACK = 1'b1
  } trk_state_e;
endpackage

// File: rtl/prbs_gen.sv
module prbs_gen #(
  parameter int LEN   = 7,
  parameter int TAP_A = 7,
  parameter int TAP_B = 6,
  parameter int unsigned SEED = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic bit_o,
  output logic valid_o
);
  localparam logic [LEN-1:0] SEED_V = LEN'(SEED);

  logic [LEN-1:0] st_q;
  logic           fb;

  assign fb = st_q[TAP_A-1] ^ st_q[TAP_B-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SEED_V;
      bit_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= en;
      if (en) begin
        st_q  <= {st_q[LEN-2:0], fb};
        bit_o <= fb;
      end
    end
  end

  // R2: the strobe follows the enable by one edge
  assert_tx_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> valid_o);
  assert_tx_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid_o);
  // R2: a nonzero seed never collapses to zero
  assert_tx_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    st_q != '0);
endmodule

// File: rtl/prbs_rx_lfsr.sv
module prbs_rx_lfsr #(
  parameter int LEN   = 7,
  parameter int TAP_A = 7,
  parameter int TAP_B = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic shift,
  input  logic seed_mode,
  input  logic din,
  output logic pred,
  output logic seed_zero
);
  logic [LEN-1:0] st_q;
  logic [LEN-1:0] seeded;

  assign pred      = st_q[TAP_A-1] ^ st_q[TAP_B-1];
  assign seeded    = {st_q[LEN-2:0], din};
  assign seed_zero = (seeded == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st_q <= '0;
    end else if (shift) begin
      st_q <= seed_mode ? seeded : {st_q[LEN-2:0], pred};
    end
  end

  // R6: while free-running the register never holds zero
  assert_track_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    !seed_mode |-> st_q != '0);
  // R5: no shift request leaves the register untouched
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!shift && !clr) |=> $stable(st_q));
endmodule

// File: rtl/prbs_lock_fsm.sv
module prbs_lock_fsm
  import prbs_bert_pkg::*;
#(
  parameter int LEN       = 7,
  parameter int WINDOW    = 64,
  parameter int FAIL_ERRS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic resync,
  input  logic valid,
  input  logic mismatch,
  input  logic seed_zero,
  output logic locked
);
  localparam int SC_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam int WC_W = $clog2(WINDOW + 1);
  localparam int EC_W = (FAIL_ERRS > 1) ? $clog2(FAIL_ERRS) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(LEN - 1);
  localparam logic [WC_W-1:0] WC_END  = WC_W'(WINDOW);
  localparam logic [EC_W-1:0] EC_LAST = EC_W'(FAIL_ERRS - 1);

  trk_state_e      st_q;
  logic [SC_W-1:0] seed_cnt_q;
  logic [WC_W-1:0] win_cnt_q;
  logic [EC_W-1:0] win_err_q;
  logic            in_window;

  assign in_window = (win_cnt_q != WC_END);
  assign locked    = (st_q == ST_TRACK);

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      st_q       <= ST_ACQ;
      seed_cnt_q <= '0;
      win_cnt_q  <= '0;
      win_err_q  <= '0;
    end else if (valid) begin
      case (st_q)
        ST_ACQ: begin
          if (seed_cnt_q == SC_LAST) begin
            seed_cnt_q <= '0;
            if (!seed_zero) begin
              st_q      <= ST_TRACK;
              win_cnt_q <= '0;
              win_err_q <= '0;
            end
          end else begin
            seed_cnt_q <= seed_cnt_q + 1'b1;
          end
        end
        ST_TRACK: begin
          if (in_window) begin
            win_cnt_q <= win_cnt_q + 1'b1;
            if (mismatch) begin
              if (win_err_q == EC_LAST) begin
                st_q       <= ST_ACQ;
                seed_cnt_q <= '0;
              end else begin
                win_err_q <= win_err_q + 1'b1;
              end
            end
          end
        end
        default: st_q <= ST_ACQ;
      endcase
    end
  end

  // R3: lock is only gained on an accepted bit
  assert_lock_needs_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (!locked && !valid) |=> !locked);
  // R7: once the window has closed, errors cannot drop lock
  assert_no_late_unlock_R7: assert property (@(posedge clk) disable iff (rst)
    (locked && !in_window && !resync) |=> locked);
  // R8: a resync always ends unlocked
  assert_resync_unlock_R8: assert property (@(posedge clk) disable iff (rst)
    resync |=> !locked);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (inc && (q != TOP)) begin
      q <= q + 1'b1;
    end
  end

  // R9: the maximum is held, never wrapped
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (q == TOP && !clr) |=> q == TOP);
  // R8: a clear empties the counter
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0);
endmodule

// File: rtl/prbs_bert.sv
module prbs_bert #(
  parameter int LEN       = 7,
  parameter int TAP_A     = 7,
  parameter int TAP_B     = 6,
  parameter int unsigned TX_SEED = 1,
  parameter int WINDOW    = 64,
  parameter int FAIL_ERRS = 4,
  parameter int CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  output logic             tx_bit,
  output logic             tx_valid,
  input  logic             rx_bit,
  input  logic             rx_valid,
  input  logic             resync,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] bit_count,
  output logic             locked
);
  logic pred;
  logic seed_zero;
  logic mismatch;
  logic cnt_en;

  prbs_gen #(.LEN(LEN), .TAP_A(TAP_A), .TAP_B(TAP_B), .SEED(TX_SEED)) u_gen (
    .clk(clk), .rst(rst), .en(tx_en), .bit_o(tx_bit), .valid_o(tx_valid)
  );

  prbs_rx_lfsr #(.LEN(LEN), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_lfsr (
    .clk(clk), .rst(rst), .clr(resync), .shift(rx_valid),
    .seed_mode(!locked), .din(rx_bit), .pred(pred), .seed_zero(seed_zero)
  );

  assign mismatch = rx_bit ^ pred;
  assign cnt_en   = rx_valid && locked && !resync;

  prbs_lock_fsm #(.LEN(LEN), .WINDOW(WINDOW), .FAIL_ERRS(FAIL_ERRS)) u_fsm (
    .clk(clk), .rst(rst), .resync(resync), .valid(rx_valid),
    .mismatch(mismatch), .seed_zero(seed_zero), .locked(locked)
  );

  sat_counter #(.W(CNT_W)) u_bits (
    .clk(clk), .rst(rst), .clr(resync), .inc(cnt_en), .q(bit_count)
  );

  sat_counter #(.W(CNT_W)) u_errs (
    .clk(clk), .rst(rst), .clr(resync), .inc(cnt_en && mismatch), .q(err_count)
  );

  // R4: counters stay frozen while unlocked
  assert_count_only_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (!locked && !resync) |=> ($stable(err_count) && $stable(bit_count)));
  // R4: errors never outnumber compared bits
  assert_err_le_bits_R4: assert property (@(posedge clk) disable iff (rst)
    err_count <= bit_count);
  // R5: an idle cycle changes nothing visible
  assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !resync) |=> ($stable(err_count) && $stable(bit_count) && $stable(locked)));
endmodule

// File: tb/sim_prbs_bert.sv
module sim_prbs_bert;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // nbits, flip position (1-based, 0 none), locked, err_count, bit_count
  localparam int unsigned TBL [NV][5] = '{
    '{7,  0, 1, 0, 0},
    '{20, 0, 1, 0, 20},
    '{10, 3, 1, 1, 30},
    '{10, 5, 1, 2, 40},
    '{30, 1, 1, 3, 70},
    '{10, 2, 1, 4, 80}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, rx_bit = 1'b0, rx_valid = 1'b0, resync = 1'b0;
  logic tx_bit, tx_valid, locked, locked1, tx_bit1, tx_valid1;
  logic [31:0] err_count, bit_count;
  logic [3:0]  err1, bits1;
  logic [6:0]  r;
  logic [6:0]  g;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs_bert u0 (.clk(clk), .rst(rst), .tx_en(tx_en), .tx_bit(tx_bit), .tx_valid(tx_valid),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .resync(resync),
    .err_count(err_count), .bit_count(bit_count), .locked(locked));

  prbs_bert #(.CNT_W(4)) u1 (.clk(clk), .rst(rst), .tx_en(tx_en), .tx_bit(tx_bit1),
    .tx_valid(tx_valid1), .rx_bit(rx_bit), .rx_valid(rx_valid), .resync(resync),
    .err_count(err1), .bit_count(bits1), .locked(locked1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic v, input logic rs);
    rx_bit = b; rx_valid = v; resync = rs;
    @(negedge clk);
    rx_valid = 1'b0; resync = 1'b0;
  endtask

  function automatic logic ref_next();
    logic fb;
    fb = r[6] ^ r[5];
    r = {r[5:0], fb};
    return fb;
  endfunction

  task automatic send_ref(input logic flip);
    logic b;
    b = ref_next();
    step(b ^ flip, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] b0;
    logic sb [7];
    int pos, guard;
    r = 7'h5A;
    g = 7'h01;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 locked", {31'd0, locked}, 0);
    chk("R1 err_count", err_count, 0);
    chk("R1 bit_count", bit_count, 0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 0);

    // R2: transmit pattern against an independent model
    tx_en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      logic e;
      e = g[6] ^ g[5];
      g = {g[5:0], e};
      @(negedge clk);
      chk("R2 tx_bit", {31'd0, tx_bit}, {31'd0, e});
      chk("R2 tx_valid", {31'd0, tx_valid}, 1);
    end
    tx_en = 1'b0;
    @(negedge clk);
    chk("R2 tx_valid low", {31'd0, tx_valid}, 0);

    // R3 R4 R7: table walk with injected errors
    for (int e = 0; e < NV; e++) begin
      for (int k = 1; k <= int'(TBL[e][0]); k++) send_ref(TBL[e][1] == k);
      chk("R3/R7 locked", {31'd0, locked}, TBL[e][2]);
      chk("R4 err_count", err_count, TBL[e][3]);
      chk("R4 bit_count", bit_count, TBL[e][4]);
    end
    chk("R9 saturated bit_count", {28'd0, bits1}, 15);
    chk("R9 err_count narrow", {28'd0, err1}, 4);

    // R5: invalid cycles are ignored
    for (int i = 0; i < 5; i++) step(i[0], 1'b0, 1'b0);
    chk("R5 err held", err_count, 4);
    chk("R5 bits held", bit_count, 80);
    chk("R5 locked held", {31'd0, locked}, 1);
    for (int i = 0; i < 20; i++) send_ref(1'b0);
    chk("R5 no new errors", err_count, 4);
    chk("R5 bits resumed", bit_count, 100);

    // R8: resync collides with a valid bit
    step(ref_next(), 1'b1, 1'b1);
    chk("R8 err cleared", err_count, 0);
    chk("R8 bits cleared", bit_count, 0);
    chk("R8 unlocked", {31'd0, locked}, 0);
    for (int i = 0; i < 6; i++) send_ref(1'b0);
    chk("R3 R8 six bits not enough", {31'd0, locked}, 0);
    send_ref(1'b0);
    chk("R3 seventh bit locks", {31'd0, locked}, 1);
    for (int i = 0; i < 10; i++) send_ref(1'b0);
    chk("R4 clean after relock err", err_count, 0);
    chk("R4 clean after relock bits", bit_count, 10);

    // R6: all-zero seed is rejected
    step(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 1'b0);
    chk("R6 zero seed stays unlocked", {31'd0, locked}, 0);
    for (int i = 0; i < 7; i++) send_ref(1'b0);
    chk("R6 fresh seed locks", {31'd0, locked}, 1);
    for (int i = 0; i < 10; i++) send_ref(1'b0);
    chk("R6 tracking err", err_count, 0);
    chk("R6 tracking bits", bit_count, 10);

    // R7: corrupted seed triggers reacquisition
    step(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 7; i++) sb[i] = ref_next();
    pos = 0;
    for (int i = 6; i >= 0; i--) if (sb[i] == 1'b0) pos = i;
    for (int i = 0; i < 7; i++) step(sb[i] ^ (i == pos), 1'b1, 1'b0);
    chk("R7 bad seed locks first", {31'd0, locked}, 1);
    guard = 0;
    while (locked && guard < 64) begin
      send_ref(1'b0);
      guard++;
    end
    chk("R7 bad seed unlocks", {31'd0, locked}, 0);
    chk("R7 fourth error counted", err_count, 4);
    for (int i = 0; i < 7; i++) send_ref(1'b0);
    chk("R7 reacquired", {31'd0, locked}, 1);
    b0 = bit_count;
    for (int i = 0; i < 30; i++) send_ref(1'b0);
    chk("R7 clean after retry err", err_count, 4);
    chk("R7 clean after retry bits", bit_count, b0 + 30);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule